// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block sits between a processor load/store port and a slower memory that works in whole lines. Each byte address is cut into a word offset, a set index and a tag. The tag is compared against every way of the indexed set at once. A hit is answered on the next cycle. A miss picks the least recently used way of the set as the victim. If that victim holds modified data, the whole line is first written back, one word per handshake. The missing line is then fetched starting at the word that was asked for. That word is handed to the processor the moment it arrives, and the rest of the line keeps filling behind it.

Stores never travel to memory directly. They mark the line dirty, and a store that misses first allocates the line and then merges its data into the arriving critical word. Only one miss is in flight at a time. The request port stays closed from the accepted miss until the last fill word has been taken.

The processor request and both memory request channels use valid/ready. A transfer happens on a rising edge where both are high. A sender holding valid must keep its address and data unchanged until ready is seen. The processor response and the fill-data stream have no back-pressure. The processor must take `rsp_valid` in the cycle it is high, and the cache takes every fill word in the cycle `fill_valid` is high. `WAYS`, `SETS` and `LINE_WORDS` must be powers of two, and `WAYS` and `SETS` must be at least 2.

Top module: `wb_cache`

## Requirements
- R1: Addresses are byte addresses. Bits [BO+WO-1:BO] select the word within the line, where BO = log2(DATA_W/8) and WO = log2(LINE_WORDS). The next log2(SETS) bits select the set, and all remaining upper bits form the tag.
- R2: A request is a hit when a valid way of its set holds its tag. At most one way matches. A hit issues no memory traffic, and a miss issues exactly one fetch request.
- R3: An accepted hit raises `rsp_valid` for one cycle, on the cycle after acceptance. For a load, `rsp_rdata` carries the current word. A store hit updates the cached word.
- R4: On a miss the victim is the least recently used way of the set. A hit makes its way the most recently used, and so does a line allocation.
- R5: Stores update only the cache and set the line's dirty bit. A dirty victim is written back in full before the fetch request is raised. The write-back sends words 0 to LINE_WORDS-1 of the line at their own byte addresses.
- R6: A store miss allocates the line and merges the store data into the fetched line at the store's word. The line is then dirty.
- R7: `fetch_addr` is the byte address of the missed word. Memory returns the line's words in wrap order, starting at that word and counting modulo LINE_WORDS.
- R8: The response to a miss is raised on the cycle after the first fill word is taken, while the rest of the line is still arriving.
- R9: Only one miss is outstanding. `req_ready` is low from the cycle after a miss is accepted until the cycle after the last fill word is taken.
- R10: After reset, `req_ready` is high, `rsp_valid`, `fetch_valid` and `evict_valid` are low, and no line is valid. The LRU order has way 0 as least recent and way WAYS-1 as most recent.
- R11: While `evict_valid` or `fetch_valid` waits for its ready, the address and data it carries stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Load data (store data echoed for stores) |
| fetch_valid | output | 1 | Line fetch request valid |
| fetch_ready | input | 1 | Memory accepts the fetch request |
| fetch_addr | output | ADDR_W | Byte address of the critical word |
| fill_valid | input | 1 | A fill word is present |
| fill_data | input | DATA_W | Fill word, in wrap order |
| evict_valid | output | 1 | Write-back word valid |
| evict_ready | input | 1 | Memory accepts the write-back word |
| evict_addr | output | ADDR_W | Byte address of the write-back word |
| evict_data | output | DATA_W | Write-back word |

## Verification
A hit answers on the first rising edge after the accepting edge, so the bench looks for `rsp_valid` 2 ns after that edge. A miss answers on the edge after the critical fill word is taken. At that sample the memory model has delivered exactly one word of the line and `req_ready` is still low. The bench drives and samples only at 2 ns after a rising edge, while the memory model acts at falling edges, so every observation falls between edges. Write-back words and fetch addresses are logged at the handshake and compared after each access against a reference model of tags, LRU ages and memory contents.

// File: rtl/wb_cache_pkg.sv
`timescale 1ns/1ps
package wb_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FETCH = 2'd2,
    ST_FILL  = 2'd3
  } cache_state_e;
endpackage

// File: rtl/wb_cache_tagstore.sv
`timescale 1ns/1ps
module wb_cache_tagstore #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 3,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  input  logic [WAY_W-1:0] vic_way,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [WAY_W-1:0] alloc_way,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx,
  input  logic [WAY_W-1:0] dirty_way
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  match;

  // one comparator per way, all in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    lk_hit = |match;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) lk_way = WAY_W'(w);
    end
  end

  assign vic_dirty = valid_q[lk_idx][vic_way] && dirty_q[lk_idx][vic_way];
  assign vic_tag   = tag_q[lk_idx][vic_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      if (alloc_en) begin
        tag_q[alloc_idx][alloc_way]   <= alloc_tag;
        valid_q[alloc_idx][alloc_way] <= 1'b1;
        dirty_q[alloc_idx][alloc_way] <= 1'b0;
      end
      if (dirty_en) dirty_q[dirty_idx][dirty_way] <= 1'b1;
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/wb_cache_lru.sv
`timescale 1ns/1ps
module wb_cache_lru #(
  parameter int IDX_W = 3,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WAY_W-1:0] q_victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way
);
  localparam int SETS = 1 << IDX_W;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // age 0 = most recent, WAYS-1 = least recent; ages form a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (age_q[q_idx][w] == OLDEST);
  end

  always_comb begin
    q_victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (oldest_vec[w]) q_victim = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_idx][w] <= '0;
        else if (age_q[touch_idx][w] < age_q[touch_idx][touch_way])
          age_q[touch_idx][w] <= age_q[touch_idx][w] + WAY_W'(1);
      end
    end
  end

  // R4
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/wb_cache_data.sv
`timescale 1ns/1ps
module wb_cache_data #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int WOFF_W = 4
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WOFF_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WOFF_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << IDX_W;
  localparam int LW   = 1 << WOFF_W;

  logic [DATA_W-1:0] line_q [SETS][WAYS][LW];

  assign rd_data = line_q[rd_idx][rd_way][rd_word];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_idx][wr_way][wr_word] <= wr_data;
  end
endmodule

// File: rtl/wb_cache.sv
`timescale 1ns/1ps
module wb_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int WAYS       = 4,
  parameter int SETS       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              evict_valid,
  input  logic              evict_ready,
  output logic [ADDR_W-1:0] evict_addr,
  output logic [DATA_W-1:0] evict_data
);
  import wb_cache_pkg::*;

  localparam int BO_W   = $clog2(DATA_W / 8);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BO_W;
  localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(LINE_WORDS - 1);

  // address split (R1)
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_woff;
  logic              unused_lsb;
  assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx    = req_addr[BO_W+WOFF_W +: IDX_W];
  assign req_woff   = req_addr[BO_W +: WOFF_W];
  assign unused_lsb = ^req_addr[BO_W-1:0];

  cache_state_e      state_q;
  logic [TAG_W-1:0]  m_tag_q, v_tag_q;
  logic [IDX_W-1:0]  m_idx_q;
  logic [WOFF_W-1:0] m_woff_q, cnt_q, fill_word;
  logic [WAY_W-1:0]  m_way_q;
  logic              m_we_q;
  logic [DATA_W-1:0] m_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic              accept, look_hit, vic_dirty;
  logic [WAY_W-1:0]  look_way, lru_victim;
  logic [TAG_W-1:0]  vic_tag;
  logic              hit_store, fill_take, crit_take;
  logic              alloc_en, dirty_en, touch_en;
  logic [IDX_W-1:0]  dirty_idx, touch_idx, rd_idx, wr_idx;
  logic [WAY_W-1:0]  dirty_way, touch_way, rd_way, wr_way;
  logic [WOFF_W-1:0] rd_word, wr_word;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_store = accept && look_hit && req_we;
  assign fill_take = (state_q == ST_FILL) && fill_valid;
  assign crit_take = fill_take && (cnt_q == '0);
  assign fill_word = m_woff_q + cnt_q;
  assign alloc_en  = (state_q == ST_FETCH) && fetch_ready;

  assign dirty_en  = hit_store || (crit_take && m_we_q);
  assign dirty_idx = hit_store ? req_idx  : m_idx_q;
  assign dirty_way = hit_store ? look_way : m_way_q;

  assign touch_en  = (accept && look_hit) || alloc_en;
  assign touch_idx = accept ? req_idx  : m_idx_q;
  assign touch_way = accept ? look_way : m_way_q;

  assign rd_idx  = (state_q == ST_EVICT) ? m_idx_q : req_idx;
  assign rd_way  = (state_q == ST_EVICT) ? m_way_q : look_way;
  assign rd_word = (state_q == ST_EVICT) ? cnt_q   : req_woff;

  assign wr_en   = hit_store || fill_take;
  assign wr_idx  = hit_store ? req_idx  : m_idx_q;
  assign wr_way  = hit_store ? look_way : m_way_q;
  assign wr_word = hit_store ? req_woff : fill_word;
  assign wr_data = hit_store ? req_wdata :
                   (crit_take && m_we_q) ? m_wdata_q : fill_data;

  wb_cache_tagstore #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_idx), .lk_tag(req_tag), .lk_hit(look_hit), .lk_way(look_way),
    .vic_way(lru_victim), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .alloc_en(alloc_en), .alloc_idx(m_idx_q), .alloc_way(m_way_q), .alloc_tag(m_tag_q),
    .dirty_en(dirty_en), .dirty_idx(dirty_idx), .dirty_way(dirty_way)
  );

  wb_cache_lru #(
    .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_n),
    .q_idx(req_idx), .q_victim(lru_victim),
    .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way)
  );

  wb_cache_data #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W), .WOFF_W(WOFF_W)
  ) u_data (
    .clk(clk),
    .rd_idx(rd_idx), .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_word(wr_word), .wr_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      m_tag_q     <= '0;
      v_tag_q     <= '0;
      m_idx_q     <= '0;
      m_woff_q    <= '0;
      m_way_q     <= '0;
      m_we_q      <= 1'b0;
      m_wdata_q   <= '0;
      cnt_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (look_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= req_we ? req_wdata : rd_data;
            end else begin
              m_tag_q   <= req_tag;
              m_idx_q   <= req_idx;
              m_woff_q  <= req_woff;
              m_we_q    <= req_we;
              m_wdata_q <= req_wdata;
              m_way_q   <= lru_victim;
              v_tag_q   <= vic_tag;
              cnt_q     <= '0;
              state_q   <= vic_dirty ? ST_EVICT : ST_FETCH;
            end
          end
        end
        ST_EVICT: begin
          if (evict_ready) begin
            cnt_q <= cnt_q + WOFF_W'(1);
            if (cnt_q == LAST_WORD) state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_ready) begin
            cnt_q   <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_valid) begin
            if (cnt_q == '0) begin
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= m_we_q ? m_wdata_q : fill_data;
            end
            cnt_q <= cnt_q + WOFF_W'(1);
            if (cnt_q == LAST_WORD) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;
  assign fetch_valid = (state_q == ST_FETCH);
  assign fetch_addr  = {m_tag_q, m_idx_q, m_woff_q, {BO_W{1'b0}}};
  assign evict_valid = (state_q == ST_EVICT);
  assign evict_addr  = {v_tag_q, m_idx_q, cnt_q, {BO_W{1'b0}}};
  assign evict_data  = rd_data;

  // R3
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && look_hit) |=> rsp_valid);

  // R8
  early_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_take |=> (rsp_valid && state_q == ST_FILL));

  // R9
  one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !look_hit) |=> !req_ready);

  // R11
  evict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_ready) |=>
      (evict_valid && $stable(evict_addr) && $stable(evict_data)));

  // R11
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));
endmodule

// File: tb/wb_cache_bench.sv
`timescale 1ns/1ps
module wb_cache_bench;
  localparam int AW = 12;
  localparam int LW = 4;
  localparam int NW = 4;
  localparam int NS = 2;
  localparam int MEMW = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          fetch_valid, fetch_ready;
  logic [AW-1:0] fetch_addr;
  logic          fill_valid;
  logic [31:0]   fill_data;
  logic          evict_valid, evict_ready;
  logic [AW-1:0] evict_addr;
  logic [31:0]   evict_data;

  int n_tests = 0, n_fail = 0;

  logic [31:0] mem  [MEMW];
  logic [31:0] refm [MEMW];
  int  rd_count = 0, wb_words = 0, k_sent = 0, rd_addr_last = 0;

  int  m_tag [NS][NW];
  bit  m_val [NS][NW];
  bit  m_dirty [NS][NW];
  int  m_age [NS][NW];

  always #10 clk = ~clk;

  wb_cache #(.ADDR_W(AW), .DATA_W(32), .LINE_WORDS(LW), .WAYS(NW), .SETS(NS)) u_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_addr(evict_addr), .evict_data(evict_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: acts at falling edges, handshakes complete at the next rising edge
  initial begin
    bit tog = 1'b0, busy = 1'b0, gapped = 1'b0;
    int dly = 0, base = 0, crit = 0;
    fetch_ready = 1'b0; evict_ready = 1'b0; fill_valid = 1'b0; fill_data = '0;
    forever begin
      @(negedge clk);
      tog = ~tog;
      evict_ready = tog;
      if (rst_n && evict_valid === 1'b1 && evict_ready) begin
        mem[int'(evict_addr) >> 2] = evict_data;
        wb_words++;
      end
      fill_valid = 1'b0;
      if (busy) begin
        fetch_ready = 1'b0;
        if (dly > 0) dly--;
        else if (k_sent == 2 && !gapped) gapped = 1'b1;
        else begin
          fill_valid = 1'b1;
          fill_data  = mem[base + ((crit + k_sent) % LW)];
          k_sent++;
          if (k_sent == LW) busy = 1'b0;
        end
      end else begin
        fetch_ready = 1'b0;
        if (rst_n && fetch_valid === 1'b1) begin
          fetch_ready = tog;
          if (tog) begin
            busy = 1'b1; dly = 2; gapped = 1'b0; k_sent = 0;
            base = (int'(fetch_addr) >> 2) & ~(LW - 1);
            crit = (int'(fetch_addr) >> 2) % LW;
            rd_count++;
            rd_addr_last = int'(fetch_addr);
          end
        end
      end
    end
  end

  task automatic touch(input int s, input int w);
    int old = m_age[s][w];
    for (int v = 0; v < NW; v++) if (m_age[s][v] < old) m_age[s][v]++;
    m_age[s][w] = 0;
  endtask

  task automatic access(input bit we, input int a, input logic [31:0] d);
    int s, tg, wi, hw, vw, rd0, wb0, cyc;
    bit hit, exp_wb;
    s  = (a >> 4) % NS;
    tg = a >> 5;
    wi = a >> 2;
    hit = 1'b0; hw = 0; vw = 0;
    for (int w = 0; w < NW; w++) if (m_val[s][w] && m_tag[s][w] == tg) begin hit = 1'b1; hw = w; end
    for (int w = 0; w < NW; w++) if (m_age[s][w] == NW - 1) vw = w;
    exp_wb = m_val[s][vw] && m_dirty[s][vw];
    rd0 = rd_count; wb0 = wb_words;
    req_we = we; req_addr = AW'(a); req_wdata = d; req_valid = 1'b1;
    while (!req_ready) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    req_valid = 1'b0;
    if (hit) begin
      chk(rsp_valid === 1'b1, "R3", "hit response one cycle after accept", 32'(rsp_valid), 1);
      chk(rd_count == rd0, "R1/R2/R4", "hit must not fetch", rd_count - rd0, 0);
      chk(wb_words == wb0, "R5", "hit must not write memory", wb_words - wb0, 0);
    end else begin
      cyc = 0;
      while (rsp_valid !== 1'b1 && cyc < 300) begin @(posedge clk); #2; cyc++; end
      chk(rsp_valid === 1'b1, "R8", "miss response seen", 32'(rsp_valid), 1);
      chk(k_sent == 1, "R8", "response after critical word only", k_sent, 1);
      chk(req_ready === 1'b0, "R9", "request port closed during back-fill", 32'(req_ready), 0);
      chk(rd_count == rd0 + 1, "R1/R2/R4", "miss fetch count", rd_count - rd0, 1);
      chk(rd_addr_last == (a & ~3), "R7", "fetch address is critical word", rd_addr_last, a & ~3);
      chk(wb_words - wb0 == (exp_wb ? LW : 0), "R5/R11", "write-back word count",
          wb_words - wb0, exp_wb ? LW : 0);
      hw = vw;
      m_tag[s][hw] = tg; m_val[s][hw] = 1'b1; m_dirty[s][hw] = 1'b0;
    end
    if (!we) chk(rsp_rdata === refm[wi], hit ? "R3" : "R7/R6", "load data", rsp_rdata, refm[wi]);
    touch(s, hw);
    if (we) begin m_dirty[s][hw] = 1'b1; refm[wi] = d; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      mem[i]  = 32'h5A00_0000 ^ (i * 32'h0001_0003);
      refm[i] = mem[i];
    end
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_tag[s][w] = 0; m_val[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_age[s][w] = NW - 1 - w;
      end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R10 reset state
    chk(req_ready === 1'b1, "R10", "req_ready after reset", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R10", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(fetch_valid === 1'b0, "R10", "fetch_valid after reset", 32'(fetch_valid), 0);
    chk(evict_valid === 1'b0, "R10", "evict_valid after reset", 32'(evict_valid), 0);
    @(posedge clk); #2;

    // clean sweep, varying critical word, more tags than ways (R1 R4 R7)
    for (int t = 0; t < 6; t++)
      for (int s = 0; s < NS; s++)
        for (int i = 0; i < LW; i++)
          access(1'b0, t * 32 + s * 16 + ((i + t + s) % LW) * 4, 32'h0);

    // stores: hits and write-allocating misses (R5 R6)
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < NS; s++)
        for (int i = 0; i < LW; i++)
          if (((i + t) % 3) != 0)
            access(1'b1, t * 32 + s * 16 + i * 4, 32'hC0DE_0000 | 32'(t * 256 + s * 16 + i));

    // new tags push dirty lines out (R5 R11)
    for (int t = 6; t < 10; t++)
      for (int s = 0; s < NS; s++)
        for (int i = 0; i < LW; i++)
          access(1'b0, t * 32 + s * 16 + ((LW - 1 - i + t) % LW) * 4, 32'h0);

    // explicit LRU ordering in set 0 (R4)
    for (int t = 10; t < 14; t++) access(1'b0, t * 32 + 4, 32'h0);
    access(1'b1, 10 * 32 + 8, 32'hBEEF_0010);
    access(1'b0, 14 * 32, 32'h0);
    access(1'b0, 10 * 32 + 12, 32'h0);
    access(1'b0, 11 * 32, 32'h0);

    // final readback of everything touched (R5 R6)
    for (int t = 0; t < 15; t++)
      for (int s = 0; s < NS; s++)
        for (int i = 0; i < LW; i++)
          access(1'b0, t * 32 + s * 16 + i * 4, 32'h0);

    repeat (30) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule